// File: doc/BRIEF.md
# Suspend Sequencer for a Packet Network Controller

This block decides when a network controller with transmit and receive DMA engines may start new work, and when it may report that it is quiescent. Software writes a suspend request bit. From the cycle after the request is seen, the block withdraws the grants that allow new DMA transfers and new frames to start. It then watches busy indications from the datapath. It declares the controller suspended once the work that must finish has finished.

The entry policy is chosen by a fast-suspend enable, which is sampled at the moment the request takes effect. In the fast policy, only work already in flight has to finish. Packets may still be sitting in buffers when the block reports suspended. In the normal policy, the transmit-frame grant stays open so the queued transmit packets can drain, and suspended is reported only after the transmit queue is empty and the wire is idle.

Clearing the request resumes operation at the ring positions that were current, and no ring rewind takes place. A stop, a soft reset or a hard reset drops the request, returns the block to idle running and rewinds the rings. The shadow copies of the encoded ring lengths are visible only while stopped or suspending. These copies ignore all resets.

Top module: `susp_seq`

## Requirements
- R1: `req_o` shows the suspend request bit. On an edge where `req_wr_i` is high, the bit takes `req_wdata_i`. It is cleared by hard reset and by any edge that sees `stop_i` or `soft_rst_i` high, and that clear overrides a write on the same edge.
- R2: Grant and busy bit mapping: bit 0 is transmit DMA, bit 1 is receive DMA, bit 2 is transmit frame and bit 3 is receive frame. All four grants are high when the block is running, `req_o` is low and `stop_i` is low. All four are low while `stop_i` is high. A request that is set drops the transmit DMA, receive DMA and receive frame grants in the first cycle `req_o` reads 1.
- R3: Fast policy: suspended rises on the edge after a cycle in which the block was draining and all four busy bits were 0, whatever `txq_pend_i` shows. During a fast drain all grants are 0.
- R4: Normal policy: while the request is pending and the block is not suspended, grant bit 2 stays high. Suspended is reached only after all busy bits are 0, and then a later cycle with `txq_pend_i` low and busy bit 2 low.
- R5: The policy is latched from `fast_en_i` on the edge that leaves running. Changing `fast_en_i` during the drain or while suspended has no effect.
- R6: If the request is cleared during a drain or while suspended, with no stop or reset, the block is running again one edge after `req_o` falls, and the grants return. `rewind_o` stays low.
- R7: `rewind_o` is high while hard reset is asserted. It is also high for the cycle after any edge that sees `stop_i` or `soft_rst_i`, and the state returns to running.
- R8: The ring-length shadows load `init_tx_len_i`/`init_rx_len_i` on an edge with `init_load_i` high and otherwise hold, through every kind of reset and stop. `tx_len_o`/`rx_len_o` show them while `stop_i` or `req_o` is high, and read 0 otherwise.
- R9: `suspended_o` is high only in the suspended state. It falls one edge after `req_o` falls, and all grants are 0 while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hard reset, asynchronous, active low |
| soft_rst_i | input | 1 | Soft reset, synchronous |
| stop_i | input | 1 | Stop control bit (level) |
| req_wr_i | input | 1 | Write strobe for the suspend request bit |
| req_wdata_i | input | 1 | Value written to the suspend request bit |
| fast_en_i | input | 1 | Fast-suspend policy enable |
| busy_i | input | 4 | In-flight indications, same mapping as the grants |
| txq_pend_i | input | 1 | Transmit FIFO/buffer still holds packets |
| init_load_i | input | 1 | Initialization writes the ring-length shadows |
| init_tx_len_i | input | LEN_W | Encoded transmit ring length from initialization |
| init_rx_len_i | input | LEN_W | Encoded receive ring length from initialization |
| grant_o | output | 4 | New-activity grants |
| suspended_o | output | 1 | Suspended status |
| req_o | output | 1 | Suspend request bit readback |
| rewind_o | output | 1 | Ring position rewind |
| tx_len_o | output | LEN_W | Transmit ring length readback |
| rx_len_o | output | LEN_W | Receive ring length readback |

## Verification
The hardest situation to reach is a normal-policy drain that sits in the transmit-queue phase while `fast_en_i` flips and the queue empties only some cycles later. A long-lived busy bit also has to survive the withdrawal of grants. The directed part of the stimulus holds busy bits across the request write, toggles the policy input mid-drain and releases the queue last. A biased random phase follows, with rare stops, soft resets and hard resets, so that these events land inside drains and while the block is suspended.

// File: rtl/susp_pkg.sv
package susp_pkg;
    localparam int NUM_CH    = 4;
    localparam int CH_TX_DMA = 0;
    localparam int CH_RX_DMA = 1;
    localparam int CH_TX_FRM = 2;
    localparam int CH_RX_FRM = 3;
    localparam int NUM_RING  = 2;

    typedef enum logic [1:0] {
        ST_RUN        = 2'd0,
        ST_DRAIN_INFL = 2'd1,
        ST_DRAIN_TXQ  = 2'd2,
        ST_SUSP       = 2'd3
    } susp_state_e;

    typedef struct packed {
        susp_state_e state;
        logic        req;
        logic        fast;
        logic        rewind;
    } ctrl_regs_t;
endpackage

// File: rtl/susp_fsm.sv
module susp_fsm
    import susp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst_i,
    input  logic              stop_i,
    input  logic              req_wr_i,
    input  logic              req_wdata_i,
    input  logic              fast_en_i,
    input  logic [NUM_CH-1:0] busy_i,
    input  logic              txq_pend_i,
    output susp_state_e       state_o,
    output logic              req_o,
    output logic              fast_o,
    output logic              rewind_o
);
    ctrl_regs_t cur_q, nxt_d;
    logic       inflight;

    always_comb begin
        nxt_d        = cur_q;
        nxt_d.rewind = 1'b0;
        inflight     = |busy_i;
        if (req_wr_i) nxt_d.req = req_wdata_i;
        case (cur_q.state)
            ST_RUN: begin
                if (cur_q.req) begin
                    nxt_d.state = ST_DRAIN_INFL;
                    nxt_d.fast  = fast_en_i;
                end
            end
            ST_DRAIN_INFL: begin
                if (!cur_q.req)     nxt_d.state = ST_RUN;
                else if (!inflight) nxt_d.state = cur_q.fast ? ST_SUSP : ST_DRAIN_TXQ;
            end
            ST_DRAIN_TXQ: begin
                if (!cur_q.req) nxt_d.state = ST_RUN;
                else if (!txq_pend_i && !busy_i[CH_TX_FRM]) nxt_d.state = ST_SUSP;
            end
            default: begin
                if (!cur_q.req) nxt_d.state = ST_RUN;
            end
        endcase
        if (stop_i || soft_rst_i) begin
            nxt_d.state  = ST_RUN;
            nxt_d.req    = 1'b0;
            nxt_d.fast   = 1'b0;
            nxt_d.rewind = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '{state: ST_RUN, req: 1'b0, fast: 1'b0, rewind: 1'b1};
        else        cur_q <= nxt_d;
    end

    assign state_o  = cur_q.state;
    assign req_o    = cur_q.req;
    assign fast_o   = cur_q.fast;
    assign rewind_o = cur_q.rewind;

    // R7
    stop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_i || soft_rst_i) |=> (!cur_q.req && cur_q.state == ST_RUN && cur_q.rewind));

    // R3
    fast_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(cur_q.state == ST_SUSP) && cur_q.fast) |-> ($past(busy_i) == '0));

    // R4
    normal_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(cur_q.state == ST_SUSP) && !cur_q.fast) |-> $past(!txq_pend_i && !busy_i[CH_TX_FRM]));

    // R5
    policy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.state != ST_RUN && !stop_i && !soft_rst_i) |=> $stable(cur_q.fast));
endmodule

// File: rtl/susp_grant.sv
module susp_grant
    import susp_pkg::*;
(
    input  susp_state_e       state_i,
    input  logic              req_i,
    input  logic              fast_q_i,
    input  logic              fast_en_i,
    input  logic              stop_i,
    output logic [NUM_CH-1:0] grant_o,
    output logic              suspended_o
);
    logic run_ok;
    logic fast_sel;
    logic txq_drain;

    always_comb begin
        run_ok      = (state_i == ST_RUN) && !req_i && !stop_i;
        fast_sel    = (state_i == ST_RUN) ? fast_en_i : fast_q_i;
        txq_drain   = req_i && !fast_sel && (state_i != ST_SUSP) && !stop_i;
        suspended_o = (state_i == ST_SUSP);
    end

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        if (ch == CH_TX_FRM) begin : g_txfrm
            assign grant_o[ch] = run_ok || txq_drain;
        end else begin : g_plain
            assign grant_o[ch] = run_ok;
        end
    end
endmodule

// File: rtl/susp_ring_len.sv
module susp_ring_len
    import susp_pkg::*;
#(
    parameter int LEN_W = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           init_load_i,
    input  logic [NUM_RING-1:0][LEN_W-1:0] len_i,
    input  logic                           vis_i,
    output logic [NUM_RING-1:0][LEN_W-1:0] len_o
);
    logic [NUM_RING-1:0][LEN_W-1:0] shadow_q, shadow_d;

    for (genvar r = 0; r < NUM_RING; r++) begin : g_ring
        always_comb begin
            shadow_d[r] = init_load_i ? len_i[r] : shadow_q[r];
            len_o[r]    = vis_i ? shadow_q[r] : '0;
        end

        always_ff @(posedge clk) begin
            shadow_q[r] <= shadow_d[r];
        end
    end

    // R8
    len_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !init_load_i |=> $stable(shadow_q));
endmodule

// File: rtl/susp_seq.sv
module susp_seq
    import susp_pkg::*;
#(
    parameter int LEN_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst_i,
    input  logic              stop_i,
    input  logic              req_wr_i,
    input  logic              req_wdata_i,
    input  logic              fast_en_i,
    input  logic [NUM_CH-1:0] busy_i,
    input  logic              txq_pend_i,
    input  logic              init_load_i,
    input  logic [LEN_W-1:0]  init_tx_len_i,
    input  logic [LEN_W-1:0]  init_rx_len_i,
    output logic [NUM_CH-1:0] grant_o,
    output logic              suspended_o,
    output logic              req_o,
    output logic              rewind_o,
    output logic [LEN_W-1:0]  tx_len_o,
    output logic [LEN_W-1:0]  rx_len_o
);
    susp_state_e                    state;
    logic                           fast_q;
    logic [NUM_RING-1:0][LEN_W-1:0] len_in, len_out;

    susp_fsm i_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_rst_i (soft_rst_i),
        .stop_i     (stop_i),
        .req_wr_i   (req_wr_i),
        .req_wdata_i(req_wdata_i),
        .fast_en_i  (fast_en_i),
        .busy_i     (busy_i),
        .txq_pend_i (txq_pend_i),
        .state_o    (state),
        .req_o      (req_o),
        .fast_o     (fast_q),
        .rewind_o   (rewind_o)
    );

    susp_grant i_grant (
        .state_i    (state),
        .req_i      (req_o),
        .fast_q_i   (fast_q),
        .fast_en_i  (fast_en_i),
        .stop_i     (stop_i),
        .grant_o    (grant_o),
        .suspended_o(suspended_o)
    );

    assign len_in = {init_rx_len_i, init_tx_len_i};

    susp_ring_len #(.LEN_W(LEN_W)) i_len (
        .clk        (clk),
        .rst_n      (rst_n),
        .init_load_i(init_load_i),
        .len_i      (len_in),
        .vis_i      (stop_i || req_o),
        .len_o      (len_out)
    );

    assign tx_len_o = len_out[0];
    assign rx_len_o = len_out[1];

    // R9
    quiet_when_susp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        suspended_o |-> (grant_o == '0));

    // R6
    resume_no_rewind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_RUN && !req_o && !stop_i && !soft_rst_i) |=> (!rewind_o && state == ST_RUN));

    // R2
    req_blocks_dma_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |-> (!grant_o[CH_TX_DMA] && !grant_o[CH_RX_DMA] && !grant_o[CH_RX_FRM]));
endmodule

// File: tb/test_susp_seq.sv
`timescale 1ns/1ps
module test_susp_seq;
    localparam int LW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          soft_rst_i = 1'b0, stop_i = 1'b0;
    logic          req_wr_i = 1'b0, req_wdata_i = 1'b0, fast_en_i = 1'b0;
    logic [3:0]    busy_i = '0;
    logic          txq_pend_i = 1'b0, init_load_i = 1'b0;
    logic [LW-1:0] init_tx_len_i = '0, init_rx_len_i = '0;
    logic [3:0]    grant_o;
    logic          suspended_o, req_o, rewind_o;
    logic [LW-1:0] tx_len_o, rx_len_o;

    int n_cmp = 0, n_bad = 0;

    // reference model state: 0 run, 1 drain in-flight, 2 drain queue, 3 suspended
    int         m_state = 0;
    bit         m_req = 0, m_fast = 0, m_rew = 1, m_len_ok = 0;
    bit [LW-1:0] m_tx = '0, m_rx = '0;

    always #2.5 clk = ~clk;

    susp_seq #(.LEN_W(LW)) i_susp_seq (
        .clk(clk), .rst_n(rst_n), .soft_rst_i(soft_rst_i), .stop_i(stop_i),
        .req_wr_i(req_wr_i), .req_wdata_i(req_wdata_i), .fast_en_i(fast_en_i),
        .busy_i(busy_i), .txq_pend_i(txq_pend_i), .init_load_i(init_load_i),
        .init_tx_len_i(init_tx_len_i), .init_rx_len_i(init_rx_len_i),
        .grant_o(grant_o), .suspended_o(suspended_o), .req_o(req_o),
        .rewind_o(rewind_o), .tx_len_o(tx_len_o), .rx_len_o(rx_len_o)
    );

    task automatic model_edge();
        int  ns;
        bit  nreq, nfast;
        if (init_load_i) begin
            m_tx = init_tx_len_i; m_rx = init_rx_len_i; m_len_ok = 1;
        end
        if (!rst_n) begin
            m_state = 0; m_req = 0; m_fast = 0; m_rew = 1;
            return;
        end
        if (stop_i || soft_rst_i) begin
            m_state = 0; m_req = 0; m_fast = 0; m_rew = 1;
            return;
        end
        ns = m_state; nfast = m_fast;
        nreq = req_wr_i ? req_wdata_i : m_req;
        if (m_state == 0) begin
            if (m_req) begin ns = 1; nfast = fast_en_i; end
        end else if (!m_req) begin
            ns = 0;
        end else if (m_state == 1) begin
            if (busy_i == 4'd0) ns = m_fast ? 3 : 2;
        end else if (m_state == 2) begin
            if (!txq_pend_i && !busy_i[2]) ns = 3;
        end
        m_state = ns; m_req = nreq; m_fast = nfast; m_rew = 0;
    endtask

    task automatic cmp(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
        end
    endtask

    task automatic compare_all();
        bit         run_ok, fsel, drain, vis;
        logic [3:0] eg;
        run_ok = (m_state == 0) && !m_req && !stop_i;
        fsel   = (m_state == 0) ? fast_en_i : m_fast;
        drain  = m_req && !fsel && (m_state != 3) && !stop_i;
        eg     = {run_ok, run_ok || drain, run_ok, run_ok};
        vis    = stop_i || m_req;
        cmp("R2 R3 R4 grant", {4'd0, grant_o}, {4'd0, eg});
        cmp("R9 R3 R4 R5 suspended", {7'd0, suspended_o}, {7'd0, m_state == 3});
        cmp("R1 req", {7'd0, req_o}, {7'd0, m_req});
        cmp("R6 R7 rewind", {7'd0, rewind_o}, {7'd0, m_rew});
        if (m_len_ok) begin
            cmp("R8 tx_len", {4'd0, tx_len_o}, {4'd0, vis ? m_tx : 4'd0});
            cmp("R8 rx_len", {4'd0, rx_len_o}, {4'd0, vis ? m_rx : 4'd0});
        end
    endtask

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            model_edge();
            @(negedge clk);
            compare_all();
            req_wr_i = 1'b0; init_load_i = 1'b0; soft_rst_i = 1'b0;
        end
    endtask

    task automatic write_req(input bit v);
        req_wr_i = 1'b1; req_wdata_i = v;
        tick();
    endtask

    initial begin
        #(200000 * 5.0);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        // reset state, with shadows loaded during hard reset (R7 R8)
        init_load_i = 1'b1; init_tx_len_i = 4'hA; init_rx_len_i = 4'h5;
        tick(2);
        rst_n = 1'b1;
        tick(3);

        // R3 fast policy: in-flight work holds it off, buffered packets do not
        fast_en_i = 1'b1; busy_i = 4'b0101; txq_pend_i = 1'b1;
        write_req(1'b1);
        tick(3);
        busy_i = 4'b0100; tick(2);
        busy_i = 4'b0000; tick(4);
        // R6 resume without rewind
        write_req(1'b0);
        tick(3);

        // R4 R5 normal policy with flipped enable mid-drain
        fast_en_i = 1'b0; busy_i = 4'b1010;
        write_req(1'b1);
        tick(2);
        fast_en_i = 1'b1; busy_i = 4'b0000; tick(3);
        busy_i = 4'b0100; tick(2);
        busy_i = 4'b0000; tick(2);
        txq_pend_i = 1'b0; tick(4);
        fast_en_i = 1'b0; tick(2);

        // R7 R8 stop while suspended, then write ignored under stop (R1)
        stop_i = 1'b1; tick(2);
        write_req(1'b1);
        init_load_i = 1'b1; init_tx_len_i = 4'h3; init_rx_len_i = 4'hC; tick(2);
        stop_i = 1'b0; tick(2);

        // R7 soft reset mid-drain
        busy_i = 4'b0001;
        write_req(1'b1);
        tick(2);
        soft_rst_i = 1'b1; tick(3);
        busy_i = 4'b0000;

        // R7 R8 hard reset while suspended keeps the shadows
        fast_en_i = 1'b1;
        write_req(1'b1);
        tick(4);
        rst_n = 1'b0; tick(2);
        rst_n = 1'b1; tick(2);
        write_req(1'b1);
        tick(3);
        write_req(1'b0);
        tick(2);

        // biased random phase
        for (int k = 0; k < 4000; k++) begin
            stop_i      = ($urandom_range(0, 39) == 0);
            soft_rst_i  = ($urandom_range(0, 59) == 0);
            req_wr_i    = ($urandom_range(0, 5) == 0);
            req_wdata_i = ($urandom_range(0, 2) != 0);
            if ($urandom_range(0, 7) == 0) fast_en_i = $urandom_range(0, 1);
            if ($urandom_range(0, 3) == 0) busy_i = 4'($urandom_range(0, 15)) & 4'($urandom_range(0, 15));
            if ($urandom_range(0, 4) == 0) txq_pend_i = $urandom_range(0, 1);
            init_load_i   = ($urandom_range(0, 29) == 0);
            init_tx_len_i = 4'($urandom_range(0, 15));
            init_rx_len_i = 4'($urandom_range(0, 15));
            rst_n         = ($urandom_range(0, 299) != 0);
            @(posedge clk);
            model_edge();
            @(negedge clk);
            compare_all();
        end
        stop_i = 1'b0; rst_n = 1'b1;
        tick(2);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule